// File: doc/BRIEF.md
# Indexed Event Counter Bank

A bank of wide event counters reached through a small register window. Software writes a selector register to choose one counter. Later accesses to the configuration, count, threshold and snapshot registers then act on that counter. Each counter watches one of the event inputs, which its condition code picks. It counts one per clock cycle in which that input is high, and it can be limited to kernel-mode or user-mode execution. A single run bit starts or halts the whole bank.

A snapshot command copies the selected counter into a holding pair, so the two halves of a 48-bit value read back coherently. Each counter has a threshold. The increment that makes the count equal to the threshold raises that counter's interrupt-active flag. An enable mask gates the active flags onto one interrupt line. Clearing an active flag also drops its enable bit, so software has to re-arm the counter explicitly.

Register addresses (4 bits): 0 control, 1 selector, 2 config, 3 count low, 4 count high, 5 snapshot low, 6 snapshot high, 7 threshold low, 8 threshold high, 9 interrupt enable, 10 interrupt active, 11 build info. Writes take effect at the next rising clock edge. Reads are combinational from `rd_addr`.

Top module: `perf_bank`

## Requirements
- R1: The selector register (address 1, bits [1:0]) chooses the counter that config, count, threshold and snapshot accesses refer to; counters not selected are unaffected by those writes.
- R2: Config bits [3:0] hold a condition code: code 0 never counts; code c from 1 to 8 counts each cycle in which `ev_in[c-1]` is high; codes above 8 never count.
- R3: Config bit 8 restricts counting to kernel mode (`mode_user`=0) and bit 9 to user mode (`mode_user`=1); with neither bit or both bits set the counter counts in either mode.
- R4: Control bit 0 enables all counters when 1 and freezes them all when 0; control bits [31:16] are stored and read back unchanged, and bits [15:1] read as 0.
- R5: Writing control with bit 1 set copies the selected counter's current value into snapshot low (address 5) and snapshot high (address 6); the snapshot keeps that value while the counter advances.
- R6: Counters are 48 bits wide; count low loads bits [31:0], count high loads bits [47:32] from write data bits [15:0], the high word reads back zero-extended, and a carry from bit 31 into bit 32 is kept.
- R7: An increment that makes a counter equal to its 48-bit threshold (addresses 7 and 8) sets that counter's bit in the interrupt-active register (address 10).
- R8: The interrupt enable register (address 9, bit i for counter i) is read/write, and `irq` is high exactly when some counter has both its active and enable bits set.
- R9: Writing 1 to a bit of the interrupt-active register clears that active bit and also clears the same bit of the enable register; writing 0 leaves both unchanged.
- R10: A write to a counter's count register in the same cycle as an event increment for that counter stores the written value, and the increment is dropped.
- R11: The build register (address 11) reads counter count in bits [7:0], the width step S in bits [11:8] (width = 32 + 16·S) and interrupt support in bit 12; with defaults it reads 0x00001104.
- R12: After reset all counters, configs, thresholds, the snapshot, control, enable and active registers are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_user | input | 1 | Current execution mode: 1 user, 0 kernel |
| ev_in | input | 8 | Event condition inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data |
| irq | output | 1 | Combined overflow interrupt |

## Verification
Two things can land on the same counter in one cycle: a software load of its count register and an event increment. The bench provokes this by holding the selected event input high during the very cycle that writes the low count word. It then reads the count back and expects exactly the written value, with no extra increment. A further single pulse afterwards confirms that counting resumes from the loaded value.

// File: rtl/perf_bank.sv
module perf_bank #(
  parameter int NCNT = 4,
  parameter int SW = 1,
  parameter int NEV = 8,
  parameter bit HAS_IRQ = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_user,
  input  logic [NEV-1:0] ev_in,
  input  logic           wr_en,
  input  logic [3:0]     wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [3:0]     rd_addr,
  output logic [31:0]    rd_data,
  output logic           irq
);
  localparam int W  = 32 + 16 * SW;
  localparam int HW = W - 32;
  localparam int IW = (NCNT > 1) ? $clog2(NCNT) : 1;

  localparam logic [3:0] A_CTRL = 4'd0, A_SEL = 4'd1, A_CFG = 4'd2, A_CLO = 4'd3,
                         A_CHI = 4'd4, A_SLO = 4'd5, A_SHI = 4'd6, A_TLO = 4'd7,
                         A_THI = 4'd8, A_IEN = 4'd9, A_IACT = 4'd10, A_BLD = 4'd11;

  logic                      run;
  logic [15:0]               ctrl_hi;
  logic [IW-1:0]             sel;
  logic [W-1:0]              snap;
  logic [NCNT-1:0]           ien, iact, hit;
  logic [NCNT-1:0][W-1:0]    cnt, thr;
  logic [NCNT-1:0][9:0]      cfg;
  logic [W-1:0]              cur, cur_thr;
  logic [9:0]                cur_cfg;
  logic [15:0]               ev_code;
  logic [NCNT-1:0]           clr;

  assign ev_code = 16'({ev_in, 1'b0});
  assign cur     = cnt[sel];
  assign cur_thr = thr[sel];
  assign cur_cfg = cfg[sel];
  assign clr     = (wr_en && wr_addr == A_IACT) ? wr_data[NCNT-1:0] : '0;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic [W-1:0] c_q, t_q;
    logic [9:0]   f_q;
    logic         wsel, wlo, whi, mode_ok, inc;

    assign wsel    = wr_en && (sel == IW'(i));
    assign wlo     = wsel && wr_addr == A_CLO;
    assign whi     = wsel && wr_addr == A_CHI;
    assign mode_ok = (f_q[8] == f_q[9]) || (f_q[8] && !mode_user) || (f_q[9] && mode_user);
    assign inc     = run && ev_code[f_q[3:0]] && mode_ok;
    assign hit[i]  = HAS_IRQ && inc && !(wlo || whi) && (c_q + W'(1) == t_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= '0;
        t_q <= '0;
        f_q <= '0;
      end else begin
        if (wlo)      c_q[31:0] <= wr_data;
        else if (whi) c_q[W-1:32] <= wr_data[HW-1:0];
        else if (inc) c_q <= c_q + W'(1);
        if (wsel && wr_addr == A_CFG) f_q <= {wr_data[9:8], 4'd0, wr_data[3:0]};
        if (wsel && wr_addr == A_TLO) t_q[31:0] <= wr_data;
        if (wsel && wr_addr == A_THI) t_q[W-1:32] <= wr_data[HW-1:0];
      end
    end

    assign cnt[i] = c_q;
    assign thr[i] = t_q;
    assign cfg[i] = f_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      ctrl_hi <= '0;
      sel     <= '0;
      snap    <= '0;
      ien     <= '0;
      iact    <= '0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) begin
        run     <= wr_data[0];
        ctrl_hi <= wr_data[31:16];
        if (wr_data[1]) snap <= cur;
      end
      if (wr_en && wr_addr == A_SEL) sel <= wr_data[IW-1:0];
      if (wr_en && wr_addr == A_IEN) ien <= wr_data[NCNT-1:0];
      else                           ien <= ien & ~clr;
      iact <= (iact & ~clr) | hit;
    end
  end

  assign irq = |(iact & ien);

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {ctrl_hi, 15'd0, run};
      A_SEL:   rd_data = 32'(sel);
      A_CFG:   rd_data = 32'(cur_cfg);
      A_CLO:   rd_data = cur[31:0];
      A_CHI:   rd_data = 32'(cur[W-1:32]);
      A_SLO:   rd_data = snap[31:0];
      A_SHI:   rd_data = 32'(snap[W-1:32]);
      A_TLO:   rd_data = cur_thr[31:0];
      A_THI:   rd_data = 32'(cur_thr[W-1:32]);
      A_IEN:   rd_data = 32'(ien);
      A_IACT:  rd_data = 32'(iact);
      A_BLD:   rd_data = 32'(NCNT) | (32'(SW) << 8) | (32'(HAS_IRQ) << 12);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/perf_bank_chk.sv
module perf_bank_chk #(
  parameter int NCNT = 4,
  parameter int W = 48
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [3:0]             wr_addr,
  input logic [31:0]            wr_data,
  input logic                   run,
  input logic [15:0]            ctrl_hi,
  input logic [NCNT-1:0]        ien,
  input logic [W-1:0]           cur,
  input logic [NCNT-1:0][W-1:0] cnt
);
  a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && (wr_addr == 4'd3 || wr_addr == 4'd4))) |=> $stable(cnt));

  a_r4_ctrl_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd0) |=> ctrl_hi == $past(wr_data[31:16]));

  a_r8_enable_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd9) |=> ien == $past(wr_data[NCNT-1:0]));

  a_r9_clear_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd10) |=> (ien & $past(wr_data[NCNT-1:0])) == '0);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd3) |=> cur[31:0] == $past(wr_data));
endmodule

bind perf_bank perf_bank_chk #(.NCNT(NCNT), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .run(run), .ctrl_hi(ctrl_hi), .ien(ien), .cur(cur), .cnt(cnt)
);

// File: tb/perf_bank_tb.sv
module perf_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_user = 1'b0;
  logic [7:0]  ev_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  perf_bank u_dut (
    .clk(clk), .rst_n(rst_n), .mode_user(mode_user), .ev_in(ev_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_irq ? 32'(irq) : rd_data;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    rd_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = 32'(e); it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      ev_in = m;
      @(negedge clk);
    end
    ev_in = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(4'd0, 32'h0, "R12 control after reset");
    rd(4'd9, 32'h0, "R12 enable after reset");
    rd(4'd10, 32'h0, "R12 active after reset");
    chk_irq(1'b0, "R12 irq after reset");
    rd(4'd11, 32'h0000_1104, "R11 build info");

    wr(4'd1, 1); wr(4'd3, 32'h100);
    wr(4'd1, 2); wr(4'd3, 32'h200);
    wr(4'd1, 1); rd(4'd3, 32'h100, "R1 counter1 via selector");
    wr(4'd1, 2); rd(4'd3, 32'h200, "R1 counter2 via selector");

    wr(4'd1, 0); wr(4'd2, 32'h3);
    wr(4'd0, 32'hABCD_0001);
    rd(4'd0, 32'hABCD_0001, "R4 control readback");
    pulse(8'h04, 5);
    rd(4'd3, 32'd5, "R2 code 3 counts ev_in[2]");
    pulse(8'h08, 2);
    rd(4'd3, 32'd5, "R2 other input ignored");
    wr(4'd1, 1);
    rd(4'd3, 32'h100, "R2 code 0 never counts");
    wr(4'd1, 0);

    wr(4'd0, 32'hABCD_0000);
    pulse(8'h04, 3);
    rd(4'd3, 32'd5, "R4 halted bank holds");
    rd(4'd0, 32'hABCD_0000, "R4 upper bits kept");
    wr(4'd0, 32'hABCD_0001);

    wr(4'd2, 32'h203);
    mode_user = 1'b0; pulse(8'h04, 2);
    rd(4'd3, 32'd5, "R3 user-only ignores kernel");
    mode_user = 1'b1; pulse(8'h04, 2);
    rd(4'd3, 32'd7, "R3 user-only counts user");
    wr(4'd2, 32'h103); pulse(8'h04, 1);
    rd(4'd3, 32'd7, "R3 kernel-only ignores user");
    wr(4'd2, 32'h303); pulse(8'h04, 1);
    rd(4'd3, 32'd8, "R3 both bits count any mode");
    mode_user = 1'b0;

    wr(4'd1, 3);
    wr(4'd4, 32'hFFFF_0012);
    rd(4'd4, 32'h12, "R6 high word 16 bits");
    wr(4'd3, 32'hFFFF_FFFE);
    wr(4'd2, 32'h1);
    pulse(8'h01, 3);
    rd(4'd4, 32'h13, "R6 carry into high word");
    rd(4'd3, 32'h1, "R6 low word after wrap");
    wr(4'd0, 32'hABCD_0003);
    rd(4'd6, 32'h13, "R5 snapshot high");
    rd(4'd5, 32'h1, "R5 snapshot low");
    pulse(8'h01, 2);
    rd(4'd5, 32'h1, "R5 snapshot holds");
    rd(4'd3, 32'h3, "R5 counter moves on");
    rd(4'd0, 32'hABCD_0001, "R4 snapshot bit reads 0");

    wr(4'd1, 2); wr(4'd2, 32'h2);
    wr(4'd7, 32'h204); wr(4'd8, 32'h0);
    wr(4'd9, 32'h4);
    rd(4'd9, 32'h4, "R8 enable readback");
    pulse(8'h02, 3);
    rd(4'd10, 32'h0, "R7 below threshold");
    chk_irq(1'b0, "R8 irq quiet below threshold");
    pulse(8'h02, 1);
    rd(4'd10, 32'h4, "R7 threshold reached");
    chk_irq(1'b1, "R8 irq raised");
    wr(4'd10, 32'h0);
    rd(4'd10, 32'h4, "R9 zero write keeps active");
    wr(4'd10, 32'h4);
    rd(4'd10, 32'h0, "R9 active cleared");
    rd(4'd9, 32'h0, "R9 enable cleared too");
    chk_irq(1'b0, "R9 irq dropped");

    wr(4'd1, 0); wr(4'd2, 32'h1);
    ev_in = 8'h01;
    wr(4'd3, 32'h50);
    ev_in = '0;
    rd(4'd3, 32'h50, "R10 write beats increment");
    pulse(8'h01, 1);
    rd(4'd3, 32'h51, "R10 counting resumes");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule